// File: doc/BRIEF.md
# Channel Offset Trim Calibration Scanner

This block finds the offset-delay trim for one pixel channel of a single-slope converter. The trim delays the start of the ramp, which moves every bin edge by a fraction of a bin. The scanner drives the trim, watches the digitised results that come back with no signal applied, and settles on the setting that puts zero signal into a chosen target bin. It is run before gain calibration, and can be run again afterwards to correct the offset a second time.

It has two methods, chosen when a run starts. The edge method suits channels with little noise. It takes one result per setting and walks the trim upward. The first setting whose result falls in the target bin becomes the lower edge. It keeps walking until the result leaves the bin, and then settles on the integer midpoint between the lower edge and the last in-bin setting. The histogram method suits channels with moderate noise. It takes a power-of-two number of dark results at every setting, counts how many fall in the target bin, and keeps the setting with the highest count.

Top module: `offset_trim_scanner`

## Requirements
- R1: After reset, trim is 0 and both done and err are 0.
- R2: Edge method: each scan starts at trim 0 and uses one valid result per setting, stepping trim by +1. The first in-bin setting is the lower edge L. The first out-of-bin setting after L is called H, and the last in-bin setting is H-1. The final trim is floor((L + H - 1) / 2), with done=1 and err=0.
- R3: Edge method: if no in-bin result is seen up to trim 15, or results are still in-bin at trim 15, the trim stays at 15 and the run ends with done=1 and err=1.
- R4: Histogram method: every setting from 0 to 15 takes 2^logSamples valid results. The final trim is the setting with the most results equal to the target bin, with err=0.
- R5: Histogram method: when hit counts are equal, the lower trim wins.
- R6: Histogram method: if no setting sees any hit, the final trim is 0 and err=1.
- R7: start is ignored while a scan is running. This includes the cycle in which the last result of the scan is accepted.
- R8: sampleValid is ignored when no scan is running. It changes neither trim nor done.
- R9: method, target bin and logSamples are captured when start is accepted. Changes to them during a scan have no effect.
- R10: done stays high, and trim and err stay unchanged, until the next start. A start while done is high gives done=0, err=0 and trim=0 in the next cycle.
- R11: While a scan is running, trim changes only by +1 per cycle, except in the cycle that sets done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run (accepted when idle or done) |
| methodSel | input | 1 | 0 = edge method, 1 = histogram method |
| targetBin | input | 8 | Bin in which zero signal should land |
| logSamples | input | 3 | log2 of the number of results per setting in the histogram method |
| sampleValid | input | 1 | A dark conversion result is present |
| sampleBin | input | 8 | Converter result taken at the current trim |
| trim | output | 4 | Offset-delay trim applied to the channel |
| done | output | 1 | Run finished; trim holds the result |
| err | output | 1 | Run ended without a valid result |

## Verification
Two things can happen in the same cycle: the result that ends a scan is accepted, and a new start request arrives. The bench raises start in the cycle it hands over the final edge-method result. It expects the run to finish normally with the midpoint trim, and it expects done to still be high one cycle later, which shows the start was dropped. A second case raises start in the middle of a scan and expects the final trim to be unchanged.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_PROB
  } calState_e;

  typedef struct packed {
    logic capture;
    logic stepTrim;
    logic latchLow;
    logic loadMid;
    logic nextSample;
    logic clrSetting;
    logic finishProb;
    logic setDone;
    logic setErr;
  } calStrobe_t;

endpackage

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int BIN_W  = 8,
  parameter int TRIM_W = 4,
  parameter int LOG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strb,
  input  logic              methodSel,
  input  logic [BIN_W-1:0]  targetBin,
  input  logic [LOG_W-1:0]  logSamples,
  input  logic [BIN_W-1:0]  sampleBin,
  output logic [TRIM_W-1:0] trim,
  output logic              capMethod,
  output logic              isHit,
  output logic              trimAtMax,
  output logic              lastSample,
  output logic              noHits
);
  localparam int CNT_W = 1 << LOG_W;
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};

  logic [TRIM_W-1:0] trimQ, lowQ, bestTrim;
  logic [BIN_W-1:0]  targetQ;
  logic [LOG_W-1:0]  logQ;
  logic [CNT_W-1:0]  smpCnt, hitCnt, bestCnt, hitNext, lastIdx;
  logic [TRIM_W:0]   midSum;
  logic              better;

  assign isHit      = (sampleBin == targetQ);
  assign trimAtMax  = (trimQ == TRIM_MAX);
  assign lastIdx    = (CNT_W'(1) << logQ) - CNT_W'(1);
  assign lastSample = (smpCnt == lastIdx);
  assign hitNext    = hitCnt + CNT_W'(isHit);
  assign better     = (hitNext > bestCnt);
  assign noHits     = !better && (bestCnt == '0);
  assign midSum     = {1'b0, lowQ} + {1'b0, trimQ} - {{TRIM_W{1'b0}}, 1'b1};
  assign trim       = trimQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trimQ     <= '0;
      lowQ      <= '0;
      bestTrim  <= '0;
      bestCnt   <= '0;
      smpCnt    <= '0;
      hitCnt    <= '0;
      targetQ   <= '0;
      logQ      <= '0;
      capMethod <= 1'b0;
    end else if (strb.capture) begin
      trimQ     <= '0;
      lowQ      <= '0;
      bestTrim  <= '0;
      bestCnt   <= '0;
      smpCnt    <= '0;
      hitCnt    <= '0;
      targetQ   <= targetBin;
      logQ      <= logSamples;
      capMethod <= methodSel;
    end else begin
      if (strb.latchLow) lowQ <= trimQ;
      if (strb.nextSample) begin
        smpCnt <= smpCnt + CNT_W'(1);
        hitCnt <= hitNext;
      end
      if (strb.clrSetting) begin
        smpCnt <= '0;
        hitCnt <= '0;
        if (better) begin
          bestTrim <= trimQ;
          bestCnt  <= hitNext;
        end
      end
      if (strb.stepTrim)        trimQ <= trimQ + TRIM_W'(1);
      else if (strb.loadMid)    trimQ <= midSum[TRIM_W:1];
      else if (strb.finishProb) trimQ <= better ? trimQ : bestTrim;
    end
  end

endmodule

// File: rtl/cal_control.sv
module cal_control
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       sampleValid,
  input  logic       methodSel,
  input  logic       isHit,
  input  logic       trimAtMax,
  input  logic       lastSample,
  input  logic       noHits,
  output calStrobe_t strb,
  output logic       busy,
  output logic       done,
  output logic       err
);
  calState_e stateQ, stateD;

  assign busy = (stateQ != ST_IDLE);

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strb.capture = 1'b1;
          stateD       = methodSel ? ST_PROB : ST_LOW;
        end
      end
      ST_LOW: begin
        if (sampleValid) begin
          if (trimAtMax) begin
            strb.setDone = 1'b1;
            strb.setErr  = 1'b1;
            stateD       = ST_IDLE;
          end else begin
            strb.stepTrim = 1'b1;
            if (isHit) begin
              strb.latchLow = 1'b1;
              stateD        = ST_HIGH;
            end
          end
        end
      end
      ST_HIGH: begin
        if (sampleValid) begin
          if (!isHit) begin
            strb.loadMid = 1'b1;
            strb.setDone = 1'b1;
            stateD       = ST_IDLE;
          end else if (trimAtMax) begin
            strb.setDone = 1'b1;
            strb.setErr  = 1'b1;
            stateD       = ST_IDLE;
          end else begin
            strb.stepTrim = 1'b1;
          end
        end
      end
      ST_PROB: begin
        if (sampleValid) begin
          if (lastSample) begin
            strb.clrSetting = 1'b1;
            if (trimAtMax) begin
              strb.finishProb = 1'b1;
              strb.setDone    = 1'b1;
              strb.setErr     = noHits;
              stateD          = ST_IDLE;
            end else begin
              strb.stepTrim = 1'b1;
            end
          end else begin
            strb.nextSample = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strb.capture) begin
        done <= 1'b0;
        err  <= 1'b0;
      end else if (strb.setDone) begin
        done <= 1'b1;
        err  <= strb.setErr;
      end
    end
  end

endmodule

// File: rtl/offset_trim_scanner.sv
module offset_trim_scanner
  import cal_pkg::*;
#(
  parameter int BIN_W  = 8,
  parameter int TRIM_W = 4,
  parameter int LOG_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              methodSel,
  input  logic [BIN_W-1:0]  targetBin,
  input  logic [LOG_W-1:0]  logSamples,
  input  logic              sampleValid,
  input  logic [BIN_W-1:0]  sampleBin,
  output logic [TRIM_W-1:0] trim,
  output logic              done,
  output logic              err
);
  calStrobe_t strb;
  logic busy, capMethod, isHit, trimAtMax, lastSample, noHits;

  cal_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .sampleValid(sampleValid),
    .methodSel  (methodSel),
    .isHit      (isHit),
    .trimAtMax  (trimAtMax),
    .lastSample (lastSample),
    .noHits     (noHits),
    .strb       (strb),
    .busy       (busy),
    .done       (done),
    .err        (err)
  );

  cal_datapath #(
    .BIN_W (BIN_W),
    .TRIM_W(TRIM_W),
    .LOG_W (LOG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .methodSel  (methodSel),
    .targetBin  (targetBin),
    .logSamples (logSamples),
    .sampleBin  (sampleBin),
    .trim       (trim),
    .capMethod  (capMethod),
    .isHit      (isHit),
    .trimAtMax  (trimAtMax),
    .lastSample (lastSample),
    .noHits     (noHits)
  );

endmodule

// File: rtl/offset_trim_scanner_chk.sv
module offset_trim_scanner_chk #(
  parameter int TRIM_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              capMethod,
  input logic [TRIM_W-1:0] trim,
  input logic              done,
  input logic              err
);
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (done || ({1'b0, trim} == {1'b0, $past(trim)}) ||
              ({1'b0, trim} == {1'b0, $past(trim)} + 1'b1))); // R11

  AST_EDGE_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (done && err && !capMethod) |-> (trim == TRIM_MAX)); // R3

  AST_HIST_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (done && err && capMethod) |-> (trim == '0)); // R6

  AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done); // R3

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(trim) && $stable(err))); // R10

  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> (!done && !err && trim == '0)); // R10

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done)); // R7

endmodule

bind offset_trim_scanner offset_trim_scanner_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .capMethod(capMethod),
  .trim     (trim),
  .done     (done),
  .err      (err)
);

// File: tb/offset_trim_scanner_bench.sv
module offset_trim_scanner_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       methodSel = 1'b0;
  logic [7:0] targetBin = 8'd0;
  logic [2:0] logSamples = 3'd0;
  logic       sampleValid = 1'b0;
  logic [7:0] sampleBin = 8'd0;
  logic [3:0] trim;
  logic       done, err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  offset_trim_scanner u_offset_trim_scanner (
    .clk(clk), .rstN(rstN), .start(start), .methodSel(methodSel),
    .targetBin(targetBin), .logSamples(logSamples), .sampleValid(sampleValid),
    .sampleBin(sampleBin), .trim(trim), .done(done), .err(err)
  );

  typedef struct packed {
    logic       m;
    logic [7:0] tgt;
    logic [4:0] a;
    logic [4:0] b;
    logic [2:0] lg;
    logic [3:0] expT;
    logic       expE;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd1,   5'd3,  5'd7,  3'd0, 4'd5,  1'b0},
    '{1'b0, 8'd1,   5'd4,  5'd9,  3'd0, 4'd6,  1'b0},
    '{1'b0, 8'd5,   5'd0,  5'd0,  3'd0, 4'd0,  1'b0},
    '{1'b0, 8'd200, 5'd14, 5'd14, 3'd0, 4'd14, 1'b0},
    '{1'b0, 8'd1,   5'd12, 5'd13, 3'd0, 4'd12, 1'b0},
    '{1'b0, 8'd1,   5'd10, 5'd15, 3'd0, 4'd15, 1'b1},
    '{1'b0, 8'd1,   5'd9,  5'd8,  3'd0, 4'd15, 1'b1},
    '{1'b0, 8'd1,   5'd15, 5'd15, 3'd0, 4'd15, 1'b1},
    '{1'b1, 8'd1,   5'd6,  5'd6,  3'd2, 4'd6,  1'b0},
    '{1'b1, 8'd3,   5'd4,  5'd7,  3'd1, 4'd4,  1'b0},
    '{1'b1, 8'd1,   5'd15, 5'd15, 3'd3, 4'd15, 1'b0},
    '{1'b1, 8'd1,   5'd9,  5'd8,  3'd2, 4'd0,  1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] modelBin(input vec_t v, input int t, input int idx);
    int n, score, da, db;
    bit inR;
    n   = 1 << v.lg;
    inR = (v.a <= v.b) && (t >= v.a) && (t <= v.b);
    if (!v.m) begin
      if (inR) return v.tgt;
      return (t < v.a) ? v.tgt + 8'd1 : v.tgt - 8'd1;
    end
    da = (t > v.a) ? t - v.a : v.a - t;
    db = (t > v.b) ? t - v.b : v.b - t;
    if (v.a > v.b) score = 0;
    else if (inR) score = n / 2 + 1;
    else if (da <= 2 || db <= 2) score = n / 4;
    else score = 0;
    return (idx < score) ? v.tgt : v.tgt + 8'd1;
  endfunction

  bit stepOk;

  task automatic runScan(input vec_t v, input int pokeTrim, input bit scramble);
    int prevT, idx, guard, lastT;
    bit poked;
    @(negedge clk);
    methodSel = v.m; targetBin = v.tgt; logSamples = v.lg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      methodSel = ~v.m; targetBin = v.tgt + 8'd50; logSamples = 3'd7;
    end
    prevT = -1; idx = 0; poked = 0; stepOk = 1; lastT = int'(trim); guard = 0;
    while (!done && guard < 5000) begin
      if (int'(trim) != lastT && int'(trim) != lastT + 1) stepOk = 0;
      lastT = int'(trim);
      if (int'(trim) != prevT) idx = 0;
      prevT = int'(trim);
      sampleValid = 1'b1;
      sampleBin = modelBin(v, int'(trim), idx);
      idx++;
      if (int'(trim) == pokeTrim && !poked) begin start = 1'b1; poked = 1; end
      else start = 1'b0;
      @(negedge clk);
      guard++;
    end
    sampleValid = 1'b0;
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(trim == 4'd0, "R1 trim", trim, 0);
    chk(!done && !err, "R1 flags", {done, err}, 0);

    sampleValid = 1'b1; sampleBin = 8'd9;
    repeat (4) @(negedge clk);
    sampleValid = 1'b0;
    chk(trim == 4'd0 && !done, "R8 idle samples", {done, trim}, 0);

    for (int i = 0; i < NV; i++) begin
      string req;
      runScan(VECS[i], -1, 0);
      if (!VECS[i].m) req = VECS[i].expE ? "R3" : "R2";
      else if (VECS[i].expE) req = "R6";
      else if (VECS[i].a < VECS[i].b) req = "R5";
      else req = "R4";
      chk(done == 1'b1, req, done, 1);
      chk(trim == VECS[i].expT, req, trim, VECS[i].expT);
      chk(err == VECS[i].expE, req, err, VECS[i].expE);
      chk(stepOk, "R11 step", stepOk, 1);
    end

    // R10: done holds, idle samples ignored (R8)
    sampleValid = 1'b1; sampleBin = 8'd1;
    repeat (5) @(negedge clk);
    sampleValid = 1'b0;
    chk(done && err && trim == 4'd0, "R8 after done", {done, err, trim}, 6'b110000);
    chk(done, "R10 hold", done, 1);

    // R10: restart clears
    start = 1'b1; methodSel = 1'b0; targetBin = 8'd1; logSamples = 3'd0;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !err && trim == 4'd0, "R10 restart", {done, err, trim}, 0);
    sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0; @(negedge clk); rstN = 1'b1; @(negedge clk);
    chk(!done && trim == 4'd0, "R1 second reset", {done, trim}, 0);

    // R7: start mid-scan ignored
    runScan(VECS[1], 4, 0);
    chk(trim == 4'd6 && done && !err, "R7 mid-scan start", trim, 6);

    // R7: start in the cycle of the final sample
    runScan(VECS[0], 8, 0);
    chk(trim == 4'd5 && done, "R7 same-cycle start", trim, 5);
    @(negedge clk);
    chk(done && trim == 4'd5, "R7 start dropped", {done, trim}, 5'h15);

    // R9: inputs changed during scan
    runScan(VECS[0], -1, 1);
    chk(trim == 4'd5 && !err, "R9 edge capture", trim, 5);
    runScan(VECS[9], -1, 1);
    chk(trim == 4'd4 && !err, "R9 hist capture", trim, 4);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule